// File: doc/BRIEF.md
# Multi-Tone Readout Waveform Synthesizer

This block builds a single digital waveform for frequency-multiplexed readout: several probe tones, each from its own phase-accumulator oscillator, are added into one stream for a DAC. Every channel carries its own frequency word, starting phase and amplitude scale, so each tone can be tuned and calibrated on its own. Tones are normally placed on an even frequency grid across the readout band.

A readout pulse opens with a start strobe and closes with a stop strobe. At the start every oscillator is reloaded to its starting phase in the same cycle, so the tones always keep the same relative phase from pulse to pulse. Settings are written at any time into a staging copy and only go live at the next start. The summed stream is clipped symmetrically to the DAC word instead of wrapping, and a sticky flag records any clipping. This flag lets software see that the combined power of the tones has overdriven the output.

Top module: `tone_synth`

## Requirements
- R1: While rst_n is low at a clock edge, dac_out becomes 0, clip_flag becomes 0, and every staged and live setting is cleared to 0.
- R2: A write (wr_en high) goes to channel wr_ch. wr_field 0 stores the 32-bit frequency word from wr_data. wr_field 1 stores the 16-bit start phase from wr_data[15:0]. wr_field 2 stores the 16-bit unsigned amplitude fraction from wr_data[15:0].
- R3: At the edge that samples pulse_start, each channel's phase becomes start_phase·2^16 and its staged frequency word and amplitude become live. dac_out shows sample n=0 after the second following edge, and then a new sample n on each edge.
- R4: Channel sample n is floor(S(p)·A/65536). Here A is the amplitude and p is the top 6 bits of (start_phase·2^16 + n·freq_word) mod 2^32. S(p) lies within ±16 of 8191·sin(2πp/64).
- R5: dac_out is the sum of all channel samples, saturated to the range −8191 … +8191. The value −8192 never appears.
- R6: clip_flag rises with the first saturated dac_out value. It stays high until a later pulse_start edge at which no saturated value is produced.
- R7: A write made during a pulse, or in the same cycle as pulse_start, does not change dac_out until the following pulse_start.
- R8: pulse_stop ends the pulse, and dac_out is 0 from the second edge after it is sampled. When both strobes are high together, pulse_start wins.
- R9: A write with wr_field 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Setting write strobe |
| wr_ch | input | 2 | Channel addressed by the write |
| wr_field | input | 2 | Setting selector: 0 frequency, 1 start phase, 2 amplitude, 3 unused |
| wr_data | input | 32 | Write value |
| pulse_start | input | 1 | Opens a readout pulse and reloads all phases |
| pulse_stop | input | 1 | Closes the readout pulse |
| dac_out | output | 14 | Signed summed, saturated waveform |
| clip_flag | output | 1 | Sticky saturation indicator |

## Verification
Two pairs of events can land in the same cycle. The first is a settings write together with pulse_start; the bench drives both in one cycle and expects the old amplitude to remain live until the next start. The second is pulse_start together with pulse_stop, where the bench expects the pulse to continue. Clipping versus flag clearing is provoked by driving four full-scale tones with equal phase, then stopping, idling and restarting at low amplitude. A per-cycle reference model fills a queue of expected samples that is compared with dac_out three negedges later.

// File: rtl/tone_synth_pkg.sv
// Package: shared setting selector codes and the sine table generator.
// Assumes the table generator is only called at elaboration time.
package tone_synth_pkg;

    typedef enum logic [1:0] {
        FLD_FREQ   = 2'd0,
        FLD_PHASE  = 2'd1,
        FLD_AMP    = 2'd2,
        FLD_UNUSED = 2'd3
    } field_e;

    // Rational sine approximation over one turn of n points, scaled to peak.
    function automatic int sine_point(input int i, input int n, input int peak);
        longint half, j, p, v;
        half = n / 2;
        j    = i % half;
        p    = j * (half - j);
        v    = (longint'(peak) * 16 * p) / (5 * half * half - 4 * p);
        return (i >= half) ? int'(-v) : int'(v);
    endfunction

endpackage

// File: rtl/tone_channel.sv
// One oscillator channel: staged and live settings, phase accumulator,
// sine lookup and amplitude scaling, with a registered output sample.
// Assumes PH_W >= OFF_W and PH_W >= AMP_W (all settings share wr_data).
module tone_channel
    import tone_synth_pkg::*;
#(
    parameter int PH_W   = 32,
    parameter int OFF_W  = 16,
    parameter int AMP_W  = 16,
    parameter int LUT_AW = 6,
    parameter int SMP_W  = 14
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [1:0]              wr_field,
    input  logic [PH_W-1:0]         wr_data,
    input  logic                    load,
    input  logic                    run,
    output logic signed [SMP_W-1:0] sample
);
    localparam int LUT_N = 1 << LUT_AW;
    localparam int PEAK  = (1 << (SMP_W - 1)) - 1;
    localparam int PW    = SMP_W + AMP_W;
    localparam int PAD   = PH_W - OFF_W;

    logic [PH_W-1:0]         sh_ftw, act_ftw, acc;
    logic [OFF_W-1:0]        sh_off;
    logic [AMP_W-1:0]        sh_amp, act_amp;
    logic signed [SMP_W-1:0] lut [LUT_N];
    logic signed [SMP_W-1:0] sine_val;
    logic signed [PW-1:0]    sine_ext, amp_ext, prod;
    logic                    lsb_unused;

    // Staging copy: catches writes at any time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_ftw <= '0;
            sh_off <= '0;
            sh_amp <= '0;
        end else if (wr_en) begin
            case (field_e'(wr_field))
                FLD_FREQ:  sh_ftw <= wr_data;
                FLD_PHASE: sh_off <= wr_data[OFF_W-1:0];
                FLD_AMP:   sh_amp <= wr_data[AMP_W-1:0];
                default:   ;
            endcase
        end
    end

    // Live copy: takes the staged values only at a pulse start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_ftw <= '0;
            act_amp <= '0;
        end else if (load) begin
            act_ftw <= sh_ftw;
            act_amp <= sh_amp;
        end
    end

    // Phase accumulator: reload to the start phase, then advance while running.
    always_ff @(posedge clk) begin
        if (!rst_n)     acc <= '0;
        else if (load)  acc <= {sh_off, PAD'(0)};
        else if (run)   acc <= acc + act_ftw;
    end

    // Sine table built from constants at elaboration.
    for (genvar g = 0; g < LUT_N; g++) begin : g_lut
        assign lut[g] = SMP_W'(sine_point(g, LUT_N, PEAK));
    end

    assign sine_val = lut[acc[PH_W-1 -: LUT_AW]];

    // Scale the signed sample by the unsigned amplitude fraction.
    always_comb begin
        sine_ext = PW'(sine_val);
        amp_ext  = PW'({1'b0, act_amp});
        prod     = sine_ext * amp_ext;
    end

    assign lsb_unused = ^prod[AMP_W-1:0];

    // Output sample register: silent outside a pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) sample <= '0;
        else        sample <= run ? prod[PW-1 -: SMP_W] : '0;
    end

    // Reload puts the staged start phase in the top bits.
    assert_reload_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> acc == {$past(sh_off), PAD'(0)});

    // Live settings never move between starts.
    assert_live_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(act_ftw) && $stable(act_amp));

endmodule

// File: rtl/tone_sum_sat.sv
// Adds all channel samples, clips symmetrically to W bits and keeps a
// sticky clip flag that a pulse start clears. Assumes NCH >= 1.
module tone_sum_sat #(
    parameter int NCH = 4,
    parameter int W   = 14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic signed [W-1:0] smp [NCH],
    output logic signed [W-1:0] dout,
    output logic                clip
);
    localparam int SW = W + $clog2(NCH) + 1;
    localparam logic signed [SW-1:0] HI = SW'((1 << (W - 1)) - 1);
    localparam logic signed [SW-1:0] LO = -HI;
    localparam logic signed [W-1:0]  NEG_END = {1'b1, {(W-1){1'b0}}};

    logic signed [SW-1:0] total;
    logic                 over_hi, over_lo;

    // Wide sum of every channel.
    always_comb begin
        total = '0;
        for (int i = 0; i < NCH; i++) total = total + SW'(smp[i]);
    end

    assign over_hi = total > HI;
    assign over_lo = total < LO;

    // Saturated output register.
    always_ff @(posedge clk) begin
        if (!rst_n)       dout <= '0;
        else if (over_hi) dout <= W'(HI);
        else if (over_lo) dout <= W'(LO);
        else              dout <= W'(total);
    end

    // Sticky flag: a clip wins over the clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                  clip <= 1'b0;
        else if (over_hi || over_lo) clip <= 1'b1;
        else if (clr)                clip <= 1'b0;
    end

    assert_no_neg_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dout != NEG_END);

    assert_clip_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clip && !clr) |=> clip);

    assert_clip_with_rail_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (over_hi || over_lo) |=> clip && (dout == W'(HI) || dout == W'(LO)));

endmodule

// File: rtl/tone_synth.sv
// Top: pulse gate, write routing and NCH oscillator channels feeding the
// saturating adder. Assumes wr_ch values >= NCH address nothing.
module tone_synth #(
    parameter int NCH    = 4,
    parameter int PH_W   = 32,
    parameter int OFF_W  = 16,
    parameter int AMP_W  = 16,
    parameter int LUT_AW = 6,
    parameter int OUT_W  = 14,
    localparam int CH_AW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [CH_AW-1:0]        wr_ch,
    input  logic [1:0]              wr_field,
    input  logic [PH_W-1:0]         wr_data,
    input  logic                    pulse_start,
    input  logic                    pulse_stop,
    output logic signed [OUT_W-1:0] dac_out,
    output logic                    clip_flag
);
    logic                    run_q;
    logic signed [OUT_W-1:0] smp [NCH];

    // Pulse gate: start has priority over stop.
    always_ff @(posedge clk) begin
        if (!rst_n)           run_q <= 1'b0;
        else if (pulse_start) run_q <= 1'b1;
        else if (pulse_stop)  run_q <= 1'b0;
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        tone_channel #(
            .PH_W(PH_W), .OFF_W(OFF_W), .AMP_W(AMP_W),
            .LUT_AW(LUT_AW), .SMP_W(OUT_W)
        ) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_en && (wr_ch == CH_AW'(g))),
            .wr_field (wr_field),
            .wr_data  (wr_data),
            .load     (pulse_start),
            .run      (run_q),
            .sample   (smp[g])
        );
    end

    tone_sum_sat #(.NCH(NCH), .W(OUT_W)) u_sum (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (pulse_start),
        .smp   (smp),
        .dout  (dac_out),
        .clip  (clip_flag)
    );

    assert_start_opens_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_start |=> run_q);

    assert_stop_closes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_stop && !pulse_start) |=> !run_q);

    assert_idle_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && $past(!run_q)) |=> dac_out == '0);

endmodule

// File: tb/tone_synth_test.sv
`timescale 1ns/1ps
module tone_synth_test;
    localparam int    NCH = 4;
    localparam real   PI  = 3.14159265358979;

    typedef struct { int val; int tol; string tag; } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [1:0]        wr_ch = '0;
    logic [1:0]        wr_field = '0;
    logic [31:0]       wr_data = '0;
    logic              pulse_start = 1'b0;
    logic              pulse_stop = 1'b0;
    logic signed [13:0] dac_out;
    logic              clip_flag;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    exp_t q[$];

    bit [31:0] sh_f [NCH], ac_f [NCH], acc [NCH];
    bit [15:0] sh_o [NCH], sh_a [NCH], ac_a [NCH];
    bit        m_run = 1'b0;

    tone_synth uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch),
        .wr_field(wr_field), .wr_data(wr_data), .pulse_start(pulse_start),
        .pulse_stop(pulse_stop), .dac_out(dac_out), .clip_flag(clip_flag)
    );

    always #2.5 clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference model output for the current model state.
    function automatic exp_t model_out(input string tag);
        exp_t e;
        real  s = 0.0;
        int   tol = 1;
        e.tag = tag;
        if (!m_run) begin
            e.val = 0; e.tol = 0;
            return e;
        end
        for (int c = 0; c < NCH; c++) begin
            s += 8191.0 * $sin(2.0 * PI * real'(acc[c][31:26]) / 64.0) * real'(ac_a[c]) / 65536.0;
            if (ac_a[c] != 0) tol += 16;
        end
        if (s > 8191.0 + tol)        begin e.val = 8191;  e.tol = 0; end
        else if (s < -8191.0 - tol)  begin e.val = -8191; e.tol = 0; end
        else                         begin e.val = int'(s); e.tol = tol; end
        return e;
    endfunction

    // Monitor compares the oldest expectation, driver applies the next edge.
    task automatic tick(input bit st, input bit sp, input bit we, input int ch,
                        input int fld, input bit [31:0] data, input string tag);
        exp_t got;
        int   d;
        @(negedge clk);
        got = q.pop_front();
        d = int'(dac_out) - got.val;
        check((d <= got.tol) && (d >= -got.tol), got.tag, int'(dac_out), got.val);
        pulse_start = st; pulse_stop = sp; wr_en = we;
        wr_ch = 2'(ch); wr_field = 2'(fld); wr_data = data;
        if (st) begin
            for (int c = 0; c < NCH; c++) begin
                ac_f[c] = sh_f[c]; ac_a[c] = sh_a[c]; acc[c] = {sh_o[c], 16'h0};
            end
            m_run = 1'b1;
        end else if (sp) m_run = 1'b0;
        else if (m_run) for (int c = 0; c < NCH; c++) acc[c] += ac_f[c];
        if (we && ch < NCH) begin
            case (fld)
                0: sh_f[ch] = data;
                1: sh_o[ch] = data[15:0];
                2: sh_a[ch] = data[15:0];
                default: ;
            endcase
        end
        q.push_back(model_out(tag));
    endtask

    task automatic wr(input int ch, input int fld, input bit [31:0] data, input string tag);
        tick(1'b0, 1'b0, 1'b1, ch, fld, data, tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) tick(1'b0, 1'b0, 1'b0, 0, 0, 32'h0, tag);
    endtask

    initial begin
        exp_t z;
        for (int c = 0; c < NCH; c++) begin
            sh_f[c] = 0; sh_o[c] = 0; sh_a[c] = 0; ac_f[c] = 0; ac_a[c] = 0; acc[c] = 0;
        end
        repeat (4) @(negedge clk);
        check(dac_out == 0, "R1 dac_out in reset", int'(dac_out), 0);
        check(clip_flag == 1'b0, "R1 clip_flag in reset", int'(clip_flag), 0);
        rst_n = 1'b1;
        z.val = 0; z.tol = 0; z.tag = "R1";
        repeat (3) q.push_back(z);

        // R2 single tone written, R7 silent until start, then R3/R4 waveform
        wr(0, 0, 32'h0400_0000, "R2");
        wr(0, 2, 32'h0000_FFFF, "R2");
        idle(4, "R7");
        tick(1'b1, 1'b0, 1'b0, 0, 0, 32'h0, "R3");
        idle(70, "R4");

        // R7 writes during a pulse stay staged; R3 restart aligns both tones
        wr(0, 0, 32'h0800_0000, "R7");
        wr(0, 2, 32'h0000_8000, "R7");
        wr(1, 1, 32'h0000_4000, "R7");
        wr(1, 0, 32'h0800_0000, "R7");
        wr(1, 2, 32'h0000_8000, "R7");
        idle(8, "R7");
        tick(1'b1, 1'b0, 1'b0, 0, 0, 32'h0, "R3");
        idle(40, "R5");

        // R9 unused selector changes nothing
        wr(0, 3, 32'hFFFF_FFFF, "R9");
        idle(3, "R9");
        tick(1'b1, 1'b0, 1'b0, 0, 0, 32'h0, "R9");
        idle(10, "R9");

        // R8 stop silences the output
        tick(1'b0, 1'b1, 1'b0, 0, 0, 32'h0, "R8");
        idle(6, "R8");

        // R5/R6 four in-phase full-scale tones clip high, then low
        for (int c = 0; c < NCH; c++) begin
            wr(c, 0, 32'h0, "R5");
            wr(c, 1, 32'h0000_4000, "R5");
            wr(c, 2, 32'h0000_FFFF, "R5");
        end
        tick(1'b1, 1'b0, 1'b0, 0, 0, 32'h0, "R5");
        idle(6, "R5");
        check(clip_flag == 1'b1, "R6 flag after high clip", int'(clip_flag), 1);
        for (int c = 0; c < NCH; c++) wr(c, 1, 32'h0000_C000, "R5");
        tick(1'b1, 1'b0, 1'b0, 0, 0, 32'h0, "R5");
        idle(6, "R5");
        tick(1'b0, 1'b1, 1'b0, 0, 0, 32'h0, "R8");
        idle(6, "R8");
        check(clip_flag == 1'b1, "R6 flag held after stop", int'(clip_flag), 1);
        for (int c = 0; c < NCH; c++) wr(c, 2, 32'h0000_1000, "R6");
        tick(1'b1, 1'b0, 1'b0, 0, 0, 32'h0, "R6");
        idle(6, "R6");
        check(clip_flag == 1'b0, "R6 flag cleared by clean start", int'(clip_flag), 0);

        // R7 write in the start cycle waits for the following start
        tick(1'b1, 1'b0, 1'b1, 0, 2, 32'h0, "R7");
        idle(4, "R7");
        tick(1'b1, 1'b0, 1'b0, 0, 0, 32'h0, "R7");
        idle(4, "R7");

        // R8 start wins over a simultaneous stop
        tick(1'b1, 1'b1, 1'b0, 0, 0, 32'h0, "R8");
        idle(5, "R8");
        tick(1'b0, 1'b1, 1'b0, 0, 0, 32'h0, "R8");
        idle(5, "R8");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule